// File: doc/BRIEF.md
# Double-Buffered Time-Slot Interchange Switch

This block reorders the words of a framed PCM bus. Each clock carries one 16-bit word for one timeslot. The block stores every incoming word at that timeslot's position in a data memory. It then sends words out in an order that a per-slot connection memory sets. The data memory has two banks that swap roles at every frame pulse: while one bank receives the current frame, the other supplies the output. As a result, a word received in frame n always leaves in frame n+1.

Each connection-memory entry has two parts: a message bit and a 16-bit field. When the message bit is clear, the low field bits name the source timeslot. When it is set, the field itself is sent as the output word. A host processor writes entries into a shadow copy of the connection memory. The shadow copy becomes active at the next frame pulse. The processor can also read back the last complete received frame.

Output can be turned off by the enable input, or by a counter-only mode. In counter-only mode the block keeps storing input but drives nothing.

Top module: `tsi_switch`

## Requirements
- R1: A high `frame_i` in a cycle makes the next cycle timeslot 0. Without a pulse the timeslot advances by one each cycle and wraps from SLOTS-1 to 0.
- R2: The bank that receives input swaps on each frame pulse. Words received between two pulses are output after the second pulse and before the third.
- R3: Output slot k is presented on `dout_o` in the cycle after slot k's input cycle. With the message bit clear (`cpu_wdata_i[16]`=0), its value is the previous frame's input at the slot named by field bits [AW-1:0].
- R4: With the message bit set (`cpu_wdata_i[16]`=1), output slot k carries the entry's 16-bit field (`cpu_wdata_i[15:0]`) instead of switched data.
- R5: A `cpu_wr_i` write to entry `cpu_addr_i` does not change the current frame's output. It takes effect from the next frame pulse, including when the write and the pulse fall in the same cycle.
- R6: A `cpu_rd_i` in a cycle returns, one cycle later on `cpu_rdata_o`, the previous frame's input word at slot `cpu_addr_i`. Without a read, `cpu_rdata_o` holds its value.
- R7: When `count_only_i` is high in a cycle, the next cycle shows `dout_oe_o`=0 and `dout_o`=0. Incoming words are still stored and are output in the next frame.
- R8: When `oe_i` is low in a cycle, the next cycle shows `dout_oe_o`=0 and `dout_o`=0.
- R9: While `rst_n` is low, `dout_o`, `dout_oe_o` and `cpu_rdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timeslot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Frame pulse, high in the last cycle of a frame |
| din_i | input | 16 | Incoming word of the current timeslot |
| oe_i | input | 1 | Output enable |
| count_only_i | input | 1 | Store-only mode, disables output |
| dout_o | output | 16 | Outgoing switched or message word |
| dout_oe_o | output | 1 | High when `dout_o` is driven |
| cpu_wr_i | input | 1 | Write strobe to the connection memory shadow copy |
| cpu_rd_i | input | 1 | Read strobe to the data memory |
| cpu_addr_i | input | AW | Entry or slot address for processor access |
| cpu_wdata_i | input | 17 | Bit 16 message flag, bits 15:0 field |
| cpu_rdata_o | output | 16 | Read-back word |

## Verification
A processor write to the connection memory can land in the same cycle as the frame pulse that loads the shadow copy. It can also land mid-frame on an entry whose slot has not yet been served. The bench does both. It writes one entry while the frame is still running and another in the pulse cycle itself. It then checks that the first leaves the rest of that frame unchanged and that both entries are in effect for the following frame. A processor read of the data memory is also issued while the switched output is reading the same bank, and both results are compared in the same cycle.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  parameter int WORD_W = 16;

  typedef struct packed {
    logic              msg;
    logic [WORD_W-1:0] field;
  } cm_entry_t;
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
  parameter int SLOTS = 32,
  parameter int AW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_i,
  output logic [AW-1:0] slot_o,
  output logic          bank_o
);
  localparam logic [AW-1:0] LAST = AW'(SLOTS - 1);

  logic [AW-1:0] slot_q, slot_d;
  logic          bank_q, bank_d;

  always_comb begin
    slot_d = slot_q;
    bank_d = bank_q;
    if (frame_i) begin
      slot_d = '0;
      bank_d = ~bank_q;
    end else if (slot_q == LAST) begin
      slot_d = '0;
    end else begin
      slot_d = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      bank_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
      bank_q <= bank_d;
    end
  end

  assign slot_o = slot_q;
  assign bank_o = bank_q;
endmodule

// File: rtl/tsi_dmem.sv
module tsi_dmem #(
  parameter int SLOTS = 32,
  parameter int AW    = $clog2(SLOTS),
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          wr_bank_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] sw_addr_i,
  output logic [DW-1:0] sw_data_o,
  input  logic [AW-1:0] cpu_addr_i,
  output logic [DW-1:0] cpu_data_o
);
  localparam int BANKS = 2;

  logic [DW-1:0] sw_rd  [BANKS];
  logic [DW-1:0] cpu_rd [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DW-1:0] mem [SLOTS];
    logic          we;

    assign we = (wr_bank_i == 1'(b));

    always_ff @(posedge clk) begin
      if (we) mem[wr_addr_i] <= wr_data_i;
    end

    assign sw_rd[b]  = mem[sw_addr_i];
    assign cpu_rd[b] = mem[cpu_addr_i];
  end

  // Both read ports look at the bank not being filled.
  assign sw_data_o  = sw_rd[~wr_bank_i];
  assign cpu_data_o = cpu_rd[~wr_bank_i];
endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem
  import tsi_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int AW    = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  cm_entry_t     wr_entry_i,
  input  logic          load_i,
  input  logic [AW-1:0] rd_addr_i,
  output cm_entry_t     rd_entry_o
);
  cm_entry_t shadow_q [SLOTS];
  cm_entry_t shadow_d [SLOTS];
  cm_entry_t active_q [SLOTS];
  cm_entry_t active_d [SLOTS];

  always_comb begin
    shadow_d = shadow_q;
    if (wr_en_i) shadow_d[wr_addr_i] = wr_entry_i;
    // A write in the load cycle is forwarded into the new active map.
    active_d = load_i ? shadow_d : active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        shadow_q[i] <= '0;
        active_q[i] <= '0;
      end
    end else begin
      if (wr_en_i) shadow_q <= shadow_d;
      if (load_i)  active_q <= active_d;
    end
  end

  assign rd_entry_o = active_q[rd_addr_i];
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int AW    = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_i,
  input  logic [WORD_W-1:0] din_i,
  input  logic              oe_i,
  input  logic              count_only_i,
  output logic [WORD_W-1:0] dout_o,
  output logic              dout_oe_o,
  input  logic              cpu_wr_i,
  input  logic              cpu_rd_i,
  input  logic [AW-1:0]     cpu_addr_i,
  input  logic [WORD_W:0]   cpu_wdata_i,
  output logic [WORD_W-1:0] cpu_rdata_o
);
  logic [AW-1:0]     slot_w;
  logic              bank_w;
  cm_entry_t         entry_w;
  cm_entry_t         wr_entry_w;
  logic [WORD_W-1:0] sw_data_w;
  logic [WORD_W-1:0] cpu_dm_w;

  logic [WORD_W-1:0] dout_q, dout_d;
  logic              oe_q, oe_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;

  tsi_timing #(.SLOTS(SLOTS), .AW(AW)) u_timing (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_i (frame_i),
    .slot_o  (slot_w),
    .bank_o  (bank_w)
  );

  assign wr_entry_w = cm_entry_t'(cpu_wdata_i);

  tsi_cmem #(.SLOTS(SLOTS), .AW(AW)) u_cmem (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (cpu_wr_i),
    .wr_addr_i  (cpu_addr_i),
    .wr_entry_i (wr_entry_w),
    .load_i     (frame_i),
    .rd_addr_i  (slot_w),
    .rd_entry_o (entry_w)
  );

  tsi_dmem #(.SLOTS(SLOTS), .AW(AW), .DW(WORD_W)) u_dmem (
    .clk        (clk),
    .wr_bank_i  (bank_w),
    .wr_addr_i  (slot_w),
    .wr_data_i  (din_i),
    .sw_addr_i  (entry_w.field[AW-1:0]),
    .sw_data_o  (sw_data_w),
    .cpu_addr_i (cpu_addr_i),
    .cpu_data_o (cpu_dm_w)
  );

  always_comb begin
    oe_d    = oe_i & ~count_only_i;
    dout_d  = '0;
    if (oe_d) dout_d = entry_w.msg ? entry_w.field : sw_data_w;
    rdata_d = cpu_rd_i ? cpu_dm_w : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      oe_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      dout_q  <= dout_d;
      oe_q    <= oe_d;
      if (cpu_rd_i) rdata_q <= rdata_d;
    end
  end

  assign dout_o      = dout_q;
  assign dout_oe_o   = oe_q;
  assign cpu_rdata_o = rdata_q;
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int SLOTS = 32,
  parameter int AW    = $clog2(SLOTS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_i,
  input logic          oe_i,
  input logic          count_only_i,
  input logic          cpu_rd_i,
  input logic [15:0]   dout_o,
  input logic          dout_oe_o,
  input logic [15:0]   cpu_rdata_o,
  input logic [AW-1:0] slot_q,
  input logic          bank_q
);
  // R1
  pulse_zeroes_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> slot_q == '0);
  // R1
  slot_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_i && slot_q != AW'(SLOTS - 1)) |=> slot_q == $past(slot_q) + 1'b1);
  // R1
  slot_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_i && slot_q == AW'(SLOTS - 1)) |=> slot_q == '0);
  // R2
  bank_swaps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> bank_q != $past(bank_q));
  // R2
  bank_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_i |=> $stable(bank_q));
  // R7
  count_only_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_only_i |=> (!dout_oe_o && dout_o == '0));
  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_i |=> (!dout_oe_o && dout_o == '0));
  // R6
  rdata_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd_i |=> $stable(cpu_rdata_o));
  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!dout_oe_o && dout_o == '0 && cpu_rdata_o == '0));
endmodule

bind tsi_switch tsi_switch_chk #(.SLOTS(SLOTS), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_i      (frame_i),
  .oe_i         (oe_i),
  .count_only_i (count_only_i),
  .cpu_rd_i     (cpu_rd_i),
  .dout_o       (dout_o),
  .dout_oe_o    (dout_oe_o),
  .cpu_rdata_o  (cpu_rdata_o),
  .slot_q       (slot_w),
  .bank_q       (bank_w)
);

// File: tb/sim_tsi_switch.sv
`timescale 1ns/1ps
module sim_tsi_switch;
  localparam int SLOTS = 32;
  localparam int AW    = $clog2(SLOTS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_i = 1'b0;
  logic [15:0]   din_i = '0;
  logic          oe_i = 1'b0;
  logic          count_only_i = 1'b0;
  logic [15:0]   dout_o;
  logic          dout_oe_o;
  logic          cpu_wr_i = 1'b0;
  logic          cpu_rd_i = 1'b0;
  logic [AW-1:0] cpu_addr_i = '0;
  logic [16:0]   cpu_wdata_i = '0;
  logic [15:0]   cpu_rdata_o;

  always #5 clk = ~clk;

  tsi_switch #(.SLOTS(SLOTS)) u0 (.*);

  typedef struct {
    int          due;
    int          kind;
    logic [15:0] exp;
    logic        exp_oe;
    string       req;
  } item_t;

  item_t       q[$];
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;
  logic [16:0] sh  [SLOTS];
  logic [16:0] act [SLOTS];
  logic [15:0] prev[SLOTS];
  logic [15:0] cur [SLOTS];
  bit          prev_ok = 0;
  int          perm[SLOTS];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: got %h expected %h at cycle %0d", req, act_v, exp_v, cyc);
    end
  endtask

  // Monitor: pops expected items as they come due.
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due == cyc) begin
        item_t it;
        it = q.pop_front();
        if (it.kind == 0) check(it.req, {15'd0, dout_oe_o, dout_o}, {15'd0, it.exp_oe, it.exp});
        else              check(it.req, {16'd0, cpu_rdata_o}, {16'd0, it.exp});
      end
    end
  end

  task automatic cpu_write(input int a, input logic [16:0] d);
    @(posedge clk); #1;
    cpu_wr_i = 1'b1; cpu_addr_i = AW'(a); cpu_wdata_i = d;
    sh[a] = d;
    @(posedge clk); #1;
    cpu_wr_i = 1'b0;
  endtask

  task automatic sync_pulse();
    @(posedge clk); #1;
    frame_i = 1'b1;
    for (int k = 0; k < SLOTS; k++) act[k] = sh[k];
    @(posedge clk); #1;
    frame_i = 1'b0;
  endtask

  // Driver: one frame; computes expected outputs from the model.
  task automatic run_frame(input int f, input bit cnt_only, input bit oe,
                           input int wr_slot, input int wr_a, input logic [16:0] wr_d,
                           input int rd_slot, input int rd_a, input string req);
    for (int s = 0; s < SLOTS; s++) begin
      logic        drive;
      logic [15:0] e;
      string       tag;
      if (s != 0) begin @(posedge clk); #1; end
      din_i        = 16'((f * 16'h0151) ^ (s * 16'h0A0B) ^ 16'h3C00);
      frame_i      = (s == SLOTS - 1);
      count_only_i = cnt_only;
      oe_i         = oe;
      cpu_wr_i     = (s == wr_slot);
      cpu_rd_i     = (s == rd_slot);
      cpu_wdata_i  = wr_d;
      cpu_addr_i   = (s == wr_slot) ? AW'(wr_a) : AW'(rd_a);
      cur[s] = din_i;
      if (prev_ok) begin
        drive = oe & ~cnt_only;
        e = act[s][16] ? act[s][15:0] : prev[act[s][AW-1:0]];
        tag = !drive ? (cnt_only ? "R7" : "R8") : (act[s][16] ? "R4" : req);
        q.push_back('{cyc + 1, 0, drive ? e : 16'h0, drive, tag});
        if (s == rd_slot) q.push_back('{cyc + 1, 1, prev[rd_a], 1'b0, "R6"});
      end
      if (s == wr_slot) sh[wr_a] = wr_d;
      if (s == SLOTS - 1) begin
        for (int k = 0; k < SLOTS; k++) begin
          act[k]  = sh[k];
          prev[k] = cur[k];
        end
        prev_ok = 1;
      end
    end
    @(posedge clk); #1;
    frame_i = 1'b0; cpu_wr_i = 1'b0; cpu_rd_i = 1'b0; count_only_i = 1'b0; oe_i = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got hung expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < SLOTS; k++) begin sh[k] = '0; act[k] = '0; perm[k] = k; end
    for (int k = SLOTS - 1; k > 0; k--) begin
      int j, t;
      j = int'($urandom_range(k, 0));
      t = perm[k]; perm[k] = perm[j]; perm[j] = t;
    end
    repeat (3) @(posedge clk);
    #2;
    // R9 reset state
    check("R9", {16'd0, dout_o}, 32'd0);
    check("R9", {31'd0, dout_oe_o}, 32'd0);
    check("R9", {16'd0, cpu_rdata_o}, 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1; oe_i = 1'b1;
    for (int k = 0; k < SLOTS; k++) cpu_write(k, {1'b0, 16'(perm[k])});
    cpu_write(7, {1'b1, 16'hA5C3});
    sync_pulse();
    @(posedge clk); #1;
    // Frame right after the pulse's next cycle must be slot 0: the pulse above
    // was followed by one idle cycle, so realign with a fresh pulse first.
    frame_i = 1'b1;
    for (int k = 0; k < SLOTS; k++) act[k] = sh[k];
    @(posedge clk); #1;
    frame_i = 1'b0;
    run_frame(0, 0, 1, -1, 0, '0, -1, 0, "R1");
    run_frame(1, 0, 1, -1, 0, '0, 3, 10, "R1");
    // R5: mid-frame write to an entry not yet served must not act this frame
    run_frame(2, 0, 1, 10, 25, {1'b0, 16'd0}, 12, 31, "R5");
    // R5: write in the pulse cycle takes effect in the next frame
    run_frame(3, 0, 1, SLOTS - 1, 4, {1'b1, 16'h1234}, 5, 0, "R5");
    run_frame(4, 0, 1, -1, 0, '0, -1, 0, "R2");
    // R7: store-only frame, then its data must appear
    run_frame(5, 1, 1, -1, 0, '0, -1, 0, "R7");
    run_frame(6, 0, 1, -1, 0, '0, 20, 9, "R7");
    // R8: outputs disabled
    run_frame(7, 0, 0, -1, 0, '0, -1, 0, "R8");
    run_frame(8, 0, 1, -1, 0, '0, 30, 2, "R3");
    repeat (4) @(posedge clk);
    #2;
    finish_run();
  end
endmodule